// File: doc/BRIEF.md
# Single-Cycle Processor Core with Array-Load, Not-Equal Branch and Rotate

This block is a compact single-cycle processor core. Every clock it fetches one 32-bit instruction from a small instruction store, decodes it, reads two source registers, computes a result and commits it to the register file, the data store and the program counter. All of this happens in one cycle. The core executes four base operations: register add, add-immediate, load word and store word. It also has three extended operations. The first is a branch taken when two registers differ. The second is a bounded array load that fetches an element and steps its pointer register in the same cycle. The third rotates a register left by an immediate amount.

A host places a program into the instruction store through a write port while reset is held, then releases reset and lets the core run. A combinational read port exposes any register so the results can be inspected. A program normally ends in a branch back to itself, which holds the PC steady.

Instruction layout: bits [31:28] opcode, [27:24] first source `rs`, [23:20] second source `rt`, [19:16] destination `rd`, [15:0] immediate `imm`. Where the immediate is used as a value, an address offset or a branch offset, it is sign-extended.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous and active high. A rising edge with `rst` high sets the PC to 0, and no register or data-store write happens while `rst` is high.
- R2: Every instruction other than a taken branch moves the PC forward by 4. Opcodes 0 and 8 to 15 are undefined and change nothing except the PC.
- R3: Opcode 1 writes `rd = rs + rt`. Opcode 2 writes `rd = rs + sext(imm)`.
- R4: The data store is word-addressed. Opcode 3 writes `rd = mem[rs + sext(imm)]`, and opcode 4 stores `rt` to `mem[rs + sext(imm)]`.
- R5: Opcode 5 is the not-equal branch. When `rs != rt` the next PC is `PC + 4 + sext(imm)`, with `imm` a byte offset. Otherwise the next PC is `PC + 4`.
- R6: Opcode 6 is the bounded array load. When `rs <= rt` holds, compared as unsigned values, it writes `rd = mem[rs]` and also writes `rs + 1` back to register `rs`, both in the same cycle.
- R7: When `rs > rt` (unsigned) for opcode 6, `rd` receives all ones and register `rs` keeps its old value.
- R8: When opcode 6 is in bounds and names the same register as `rd` and `rs`, that register receives the loaded word and the pointer increment is dropped.
- R9: Opcode 7 writes `rd` with `rs` rotated left by `imm[4:0]`. Bits shifted out of bit 31 come back in at bit 0. An amount whose low five bits are zero, for example 32, returns `rs` unchanged.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: `dbg_data` shows the current value of register `dbg_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | IMEM_AW | Instruction store word index to write |
| prog_data | input | 32 | Instruction word to write |
| dbg_sel | input | 4 | Register index to observe |
| dbg_data | output | 32 | Value of the selected register |
| pc | output | 32 | Current program counter (byte address) |

## Verification
Two of the core's functions can act on the same register in one cycle: the loaded-element write and the pointer post-increment of the array load. A program provokes this by issuing an in-bounds array load whose destination and pointer are the same register. It passes only if that register ends up holding the memory element and not the incremented pointer. The bench also runs the pointer past its bound and uses an all-ones pointer against a small bound, so that the all-ones result, the untouched pointer and the unsigned comparison are each checked against values computed in the bench.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [31:0]        prog_data,
  input  logic [3:0]         dbg_sel,
  output logic [31:0]        dbg_data,
  output logic [31:0]        pc
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;
  localparam logic [3:0] OP_ADD  = 4'h1;
  localparam logic [3:0] OP_ADDI = 4'h2;
  localparam logic [3:0] OP_LW   = 4'h3;
  localparam logic [3:0] OP_SW   = 4'h4;
  localparam logic [3:0] OP_BNE  = 4'h5;
  localparam logic [3:0] OP_LA   = 4'h6;
  localparam logic [3:0] OP_ROT  = 4'h7;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [16];
  logic [31:0] pc_q, next_pc;

  assign pc = pc_q;

  wire [31:0] instr = imem[pc_q[IMEM_AW+1:2]];
  wire [3:0]  op    = instr[31:28];
  wire [3:0]  rs    = instr[27:24];
  wire [3:0]  rt    = instr[23:20];
  wire [3:0]  rd    = instr[19:16];
  wire [15:0] imm   = instr[15:0];
  wire [31:0] simm  = {{16{imm[15]}}, imm};

  wire [31:0] rs_v = (rs == 4'd0) ? 32'd0 : rf[rs];
  wire [31:0] rt_v = (rt == 4'd0) ? 32'd0 : rf[rt];
  assign dbg_data  = (dbg_sel == 4'd0) ? 32'd0 : rf[dbg_sel];

  wire [31:0]        eff_addr  = rs_v + simm;
  wire [DMEM_AW-1:0] ld_idx    = (op == OP_LA) ? rs_v[DMEM_AW-1:0] : eff_addr[DMEM_AW-1:0];
  wire [31:0]        ld_word   = dmem[ld_idx];
  wire               in_bounds = rs_v <= rt_v;

  wire [4:0]  amt = imm[4:0];
  wire [31:0] rot = (amt == 5'd0) ? rs_v : ((rs_v << amt) | (rs_v >> (6'd32 - {1'b0, amt})));

  logic        we_a, we_b, st_en;
  logic [31:0] wd_a;

  always_comb begin
    we_a    = 1'b0;
    we_b    = 1'b0;
    st_en   = 1'b0;
    wd_a    = 32'd0;
    next_pc = pc_q + 32'd4;
    case (op)
      OP_ADD:  begin we_a = 1'b1; wd_a = rs_v + rt_v; end
      OP_ADDI: begin we_a = 1'b1; wd_a = eff_addr; end
      OP_LW:   begin we_a = 1'b1; wd_a = ld_word; end
      OP_SW:   st_en = 1'b1;
      OP_BNE:  if (rs_v != rt_v) next_pc = pc_q + 32'd4 + simm;
      OP_LA:   begin
                 we_a = 1'b1;
                 wd_a = in_bounds ? ld_word : '1;
                 we_b = in_bounds;
               end
      OP_ROT:  begin we_a = 1'b1; wd_a = rot; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= 32'd0;
    end else begin
      pc_q <= next_pc;
      if (st_en) dmem[eff_addr[DMEM_AW-1:0]] <= rt_v;
      if (we_b && rs != 4'd0 && !(we_a && rd == rs)) rf[rs] <= rs_v + 32'd1;
      if (we_a && rd != 4'd0) rf[rd] <= wd_a;
    end
  end

  wire unused_bits = ^{pc_q[1:0], pc_q[31:IMEM_AW+2], eff_addr[31:DMEM_AW]};

  logic live;
  always_ff @(posedge clk) live <= !rst;

  wire [63:0] rot_ref = {rs_v, rs_v} << amt;

  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == 32'd0);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op) != OP_BNE) |-> pc == $past(pc_q) + 32'd4);

  // R7
  la_oob_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op == OP_LA && !in_bounds && rs != rd && rs != 4'd0))
      |-> rf[$past(rs)] == $past(rs_v));

  // R8
  la_same_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op == OP_LA && in_bounds && rs == rd && rd != 4'd0))
      |-> rf[$past(rd)] == $past(ld_word));

  // R9
  rot_result_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op == OP_ROT && rd != 4'd0))
      |-> rf[$past(rd)] == $past(rot_ref[63:32]));
endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [3:0]  dbg_sel = '0;
  logic [31:0] dbg_data, pc;

  int checks = 0;
  int fails = 0;
  logic [31:0] prog [64];
  int n;

  always #2 clk = ~clk;

  sc_core dut (.clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
               .prog_data(prog_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data), .pc(pc));

  function automatic logic [31:0] ins(int op, int rs, int rt, int rd, int imm);
    return {op[3:0], rs[3:0], rt[3:0], rd[3:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] rotl(logic [31:0] v, int k);
    int m = k % 32;
    if (m == 0) return v;
    return (v << m) | (v >> (32 - m));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic emit(logic [31:0] w);
    prog[n] = w;
    n++;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
    n = 0;
  endtask

  task automatic run(int cycles);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      prog_we = 1'b1; prog_addr = i[5:0]; prog_data = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
    chk("R1 pc held at zero in reset", pc, 32'd0);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic reg_is(string tag, int idx, logic [31:0] exp);
    dbg_sel = idx[3:0];
    #1;
    chk(tag, dbg_data, exp);
  endtask

  task automatic halt(int nz_reg);
    emit(ins(5, 0, nz_reg, 0, -4));
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] vals [2];
    int bases [3];
    int hpc;
    vals[0] = 32'h1234_5678;
    vals[1] = 32'h0F0F_0001;
    bases[0] = 0; bases[1] = 14; bases[2] = 28;

    // R9 rotate sweep over amounts 0..41 for two values
    for (int v = 0; v < 2; v++) begin
      for (int b = 0; b < 3; b++) begin
        clear_prog();
        emit(ins(2, 0, 0, 1, vals[v][31:16]));
        emit(ins(7, 1, 0, 1, 16));
        emit(ins(2, 1, 0, 1, vals[v][15:0]));
        for (int j = 0; j < 14; j++) emit(ins(7, 1, 0, 2 + j, bases[b] + j));
        hpc = n * 4;
        halt(1);
        run(40);
        reg_is("R9 source value", 1, vals[v]);
        for (int j = 0; j < 14; j++)
          reg_is($sformatf("R9 rotate by %0d", bases[b] + j), 2 + j, rotl(vals[v], bases[b] + j));
        chk("R5 halt loop holds pc", pc, hpc);
      end
    end

    // R3 R4 R10 R11 R2 base ops, zero register, undefined opcodes
    clear_prog();
    emit(ins(2, 0, 0, 1, 100));
    emit(ins(2, 0, 0, 2, -3));
    emit(ins(1, 1, 2, 3, 0));
    emit(ins(4, 1, 3, 0, -90));
    emit(ins(3, 0, 0, 4, 10));
    emit(ins(2, 0, 0, 0, 5));
    emit(ins(1, 0, 0, 5, 0));
    emit(ins(2, 0, 0, 6, 77));
    emit(ins(15, 1, 2, 6, 3));
    emit(ins(8, 1, 1, 6, 1));
    emit(ins(0, 1, 2, 6, 0));
    emit(ins(2, 0, 0, 7, 1));
    hpc = n * 4;
    halt(7);
    run(30);
    reg_is("R3 addi", 1, 32'd100);
    reg_is("R3 addi negative", 2, 32'hFFFF_FFFD);
    reg_is("R3 add", 3, 32'd97);
    reg_is("R4 store then load", 4, 32'd97);
    reg_is("R10 r0 reads zero", 0, 32'd0);
    reg_is("R10 r0 write ignored", 5, 32'd0);
    reg_is("R2 undefined opcodes leave rd", 6, 32'd77);
    reg_is("R11 dbg port and R2 execution continues", 7, 32'd1);
    chk("R2 pc reaches halt", pc, hpc);

    // R5 branches
    clear_prog();
    emit(ins(2, 0, 0, 1, 5));
    emit(ins(2, 0, 0, 2, 5));
    emit(ins(2, 0, 0, 3, 0));
    emit(ins(2, 0, 0, 5, 0));
    emit(ins(2, 0, 0, 6, 0));
    emit(ins(2, 0, 0, 10, 0));
    emit(ins(5, 1, 2, 0, 4));
    emit(ins(2, 0, 0, 3, 1));
    emit(ins(2, 0, 0, 4, 6));
    emit(ins(5, 1, 4, 0, 4));
    emit(ins(2, 0, 0, 5, 1));
    emit(ins(2, 0, 0, 6, 7));
    emit(ins(5, 1, 4, 0, 12));
    emit(ins(2, 0, 0, 10, 1));
    emit(ins(2, 0, 0, 10, 2));
    emit(ins(2, 0, 0, 10, 3));
    emit(ins(2, 0, 0, 7, 0));
    emit(ins(2, 0, 0, 8, 3));
    emit(ins(2, 7, 0, 7, 1));
    emit(ins(5, 7, 8, 0, -8));
    emit(ins(2, 0, 0, 9, 9));
    hpc = n * 4;
    halt(9);
    run(60);
    reg_is("R5 equal operands fall through", 3, 32'd1);
    reg_is("R5 taken branch skips one", 5, 32'd0);
    reg_is("R5 target executes", 6, 32'd7);
    reg_is("R5 forward offset 12", 10, 32'd0);
    reg_is("R5 backward loop count", 7, 32'd3);
    reg_is("R5 after loop", 9, 32'd9);
    chk("R5 pc at halt", pc, hpc);

    // R6 R7 R8 bounded array load
    clear_prog();
    for (int i = 0; i < 5; i++) begin
      emit(ins(2, 0, 0, 1, 11 * (i + 1)));
      emit(ins(4, 0, 1, 0, i));
    end
    emit(ins(2, 0, 0, 2, 0));
    emit(ins(2, 0, 0, 3, 4));
    for (int i = 0; i < 6; i++) emit(ins(6, 2, 3, 4 + i, 0));
    emit(ins(2, 0, 0, 10, -1));
    emit(ins(2, 0, 0, 12, 1));
    emit(ins(6, 10, 12, 11, 0));
    emit(ins(2, 0, 0, 13, 1));
    emit(ins(6, 13, 3, 13, 0));
    emit(ins(2, 0, 0, 14, 4));
    emit(ins(6, 14, 3, 15, 0));
    hpc = n * 4;
    halt(3);
    run(50);
    for (int i = 0; i < 5; i++)
      reg_is($sformatf("R6 element %0d", i), 4 + i, 11 * (i + 1));
    reg_is("R7 past bound gives all ones", 9, 32'hFFFF_FFFF);
    reg_is("R6 R7 pointer stops at 5", 2, 32'd5);
    reg_is("R7 unsigned compare result", 11, 32'hFFFF_FFFF);
    reg_is("R7 pointer unchanged", 10, 32'hFFFF_FFFF);
    reg_is("R8 same register gets element", 13, 32'd22);
    reg_is("R6 equal bound loads", 15, 32'd55);
    reg_is("R6 equal bound increments", 14, 32'd5);
    chk("R2 pc at halt after loads", pc, hpc);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset returns pc to zero", pc, 32'd0);
    reg_is("R1 no write during reset", 15, 32'd55);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 first step after reset", pc, 32'd4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule